// File: doc/BRIEF.md
# Slot-Mapped Audio Sample FIFO

This block is an eight-entry, 16-bit sample queue between a processor's register interface and a time-division multiplexed audio frame. A parameter selects the variant. The transmit variant takes words from the processor and hands them out on frame slot requests. The receive variant captures frame slot words and holds them until the processor reads them. A single control word binds the queue to one frame slot, or in stereo mode to a pair of adjacent slots. The same word connects or disconnects the queue and sets a fill threshold for a level interrupt. It also reports full and empty, plus a sticky error that records slot service the queue could not meet.

The frame side presents a strobe with a slot index for every slot time. The receive variant also gets 20-bit slot data on that side. The block claims the slots it is bound to. A receive claim stores the top 16 bits of the slot data. A transmit claim supplies the head word, widened to 20 bits, in the same cycle. In stereo mode the lower slot carries the left sample and the upper slot carries the right sample, so left and right words alternate in the queue with left first.

Top module: `slot_fifo`

## Requirements
- R1: After reset the control word reads 16'h4000 (only the empty flag set). The interrupt, slot_take, slot_dout and dat_rdata are all zero.
- R2: Control word fields are: [1:0] connection (2'b10 connected, any other value disconnected); [3] stereo; [7:4] slot number; [10:8] threshold; [11] DMA request enable. These fields read back as written. Bits 2 and 12 always read 0. Bit 13 is full and bit 14 is empty, and writes to either have no effect. Bit 15 is the error flag.
- R3: In mono mode with a connected queue and slot number 3 to 12, slot_take is high in the strobe cycle exactly when slot_idx equals the slot number. A slot number outside 3 to 12 claims nothing.
- R4: In stereo mode the queue claims the slot number and the slot number plus one. Claims happen in strobe order, so the lower (left) slot's word comes first. Stereo with slot number 12 claims nothing.
- R5: The queue keeps first-in first-out order for up to 8 words. The full flag reads 1 exactly when 8 words are held.
- R6: A receive claim stores slot_din[19:4]. Bits [3:0] are discarded.
- R7: A transmit claim with words held drives slot_dout = {head word, 4'b0000} in the claim cycle and removes that word. Without a claim, slot_dout is zero.
- R8: The transmit interrupt is high while connected and empty entries are at least threshold+1. The receive interrupt is high while connected and held words are at least threshold+1. Both interrupts are levels.
- R9: A transmit claim while empty sets the error flag and drives slot_dout to zero.
- R10: A receive claim while full sets the error flag and drops the word.
- R11: Writing the control word with bit 15 at 1 clears the error flag. When a new error occurs in the same cycle, the set wins.
- R12: While disconnected, slot strobes are not claimed, the error flag does not change and the held words stay. The unused data port of each variant is ignored: the transmit variant's dat_rdata stays zero.
- R13: A push to a full transmit queue is dropped. A pop from an empty receive queue is ignored, and dat_rdata reads zero while the receive queue is empty.
- R14: A register-side operation and a slot claim may fall in the same cycle. Full and empty are judged on the occupancy before that clock edge, so a push to a full queue is dropped even when a pop happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write value |
| cfg_rdata | output | 16 | Control and status read value |
| dat_we | input | 1 | Register-side push (transmit variant) |
| dat_wdata | input | 16 | Word to push |
| dat_re | input | 1 | Register-side pop (receive variant) |
| dat_rdata | output | 16 | Head word of the receive queue, zero when empty |
| slot_stb | input | 1 | Slot time strobe from the frame side |
| slot_idx | input | 4 | Index of the current slot |
| slot_din | input | 20 | Received slot data |
| slot_take | output | 1 | The current slot is claimed by this queue |
| slot_dout | output | 20 | Transmit slot data |
| irq | output | 1 | Level interrupt at the programmed threshold |

## Verification
The delicate case is a register-side push or pop landing in the same cycle as a slot claim. On a full or empty queue this decides whether the word is kept and whether the error flag rises. The bench runs directed cycles that push while a claim drains a full transmit queue, and that pop while a claim arrives at a full receive queue. It also clears the error in the very cycle a fresh underflow occurs. Every cycle, random traffic mixes these operations against a bench queue model whose accept rules come from R14 and R11.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

  localparam logic [1:0] CONN_ON = 2'b10;
  localparam logic [3:0] SLOT_LO = 4'd3;
  localparam logic [3:0] SLOT_HI = 4'd12;

  typedef struct packed {
    logic       dma_en;
    logic [2:0] thr;
    logic [3:0] slot;
    logic       stereo;
    logic [1:0] conn;
  } cfg_t;

  function automatic cfg_t cfg_from_word(logic [15:0] w);
    cfg_t c;
    c.dma_en = w[11];
    c.thr    = w[10:8];
    c.slot   = w[7:4];
    c.stereo = w[3];
    c.conn   = w[1:0];
    return c;
  endfunction

  function automatic logic [15:0] status_word(cfg_t c, logic err, logic empty, logic full);
    return {err, empty, full, 1'b0, c.dma_en, c.thr, c.slot, c.stereo, 1'b0, c.conn};
  endfunction

  function automatic logic is_live(cfg_t c);
    return c.conn == CONN_ON;
  endfunction

  // Slot binding: one slot in mono, slot and slot+1 in stereo.
  function automatic logic slot_hit(cfg_t c, logic [3:0] idx);
    logic legal;
    logic second;
    legal  = (c.slot >= SLOT_LO) && (c.slot <= SLOT_HI) &&
             !(c.stereo && (c.slot == SLOT_HI));
    second = c.stereo && (idx == c.slot + 4'd1);
    return is_live(c) && legal && ((idx == c.slot) || second);
  endfunction

  // Transmit: enough free entries.
  function automatic logic room_irq(cfg_t c, int fill, int depth);
    return is_live(c) && ((depth - fill) > int'(c.thr));
  endfunction

  // Receive: enough stored words.
  function automatic logic fill_irq(cfg_t c, int fill);
    return is_live(c) && (fill > int'(c.thr));
  endfunction

endpackage

// File: rtl/sfifo_cfg_reg.sv
module sfifo_cfg_reg
  import sfifo_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [15:0] wdata,
  input  logic        err_set,
  output cfg_t        cfg,
  output logic        err
);

  logic clr_req;
  assign clr_req = wr && wdata[15];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
      err <= 1'b0;
    end else begin
      if (wr) cfg <= cfg_from_word(wdata);
      if (err_set)      err <= 1'b1;
      else if (clr_req) err <= 1'b0;
    end
  end

  assert_w1c_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req && !err_set |=> !err);
  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err && !clr_req |=> err);
  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> err);

endmodule

// File: rtl/sfifo_ring.sv
module sfifo_ring #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          push_ok,
  output logic          pop_ok
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr;
  logic [AW-1:0] wr_ptr;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = count == CW'(DEPTH);
  assign empty   = count == '0;
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  assert_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_full_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop |=> full);

endmodule

// File: rtl/sfifo_slot_match.sv
module sfifo_slot_match
  import sfifo_pkg::*;
(
  input  cfg_t       cfg,
  input  logic       stb,
  input  logic [3:0] idx,
  output logic       claim
);

  assign claim = stb && slot_hit(cfg, idx);

endmodule

// File: rtl/slot_fifo.sv
module slot_fifo
  import sfifo_pkg::*;
#(
  parameter bit IS_TX  = 1'b1,
  parameter int DEPTH  = 8,
  parameter int W      = 16,
  parameter int SLOT_W = 20,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int PAD   = SLOT_W - W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  input  logic              dat_we,
  input  logic [W-1:0]      dat_wdata,
  input  logic              dat_re,
  output logic [W-1:0]      dat_rdata,
  input  logic              slot_stb,
  input  logic [3:0]        slot_idx,
  input  logic [SLOT_W-1:0] slot_din,
  output logic              slot_take,
  output logic [SLOT_W-1:0] slot_dout,
  output logic              irq
);

  cfg_t          cfg;
  logic          err;
  logic          claim;
  logic          starve;
  logic          r_push;
  logic          r_pop;
  logic [W-1:0]  r_din;
  logic [W-1:0]  head;
  logic [CW-1:0] count;
  logic          full;
  logic          empty;
  logic          push_ok;
  logic          pop_ok;

  sfifo_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (cfg_we),
    .wdata   (cfg_wdata),
    .err_set (claim && starve),
    .cfg     (cfg),
    .err     (err)
  );

  sfifo_slot_match u_match (
    .cfg   (cfg),
    .stb   (slot_stb),
    .idx   (slot_idx),
    .claim (claim)
  );

  sfifo_ring #(.W(W), .DEPTH(DEPTH)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (r_push),
    .din     (r_din),
    .pop     (r_pop),
    .head    (head),
    .count   (count),
    .full    (full),
    .empty   (empty),
    .push_ok (push_ok),
    .pop_ok  (pop_ok)
  );

  assign cfg_rdata = status_word(cfg, err, empty, full);
  assign slot_take = claim;

  if (IS_TX) begin : g_tx
    logic unused_tx;
    assign r_push    = dat_we;
    assign r_din     = dat_wdata;
    assign r_pop     = claim;
    assign starve    = empty;
    assign irq       = room_irq(cfg, int'(count), DEPTH);
    assign slot_dout = (claim && !empty) ? {head, {PAD{1'b0}}} : '0;
    assign dat_rdata = '0;
    assign unused_tx = ^{dat_re, slot_din, push_ok, pop_ok};

    // R9: an unmet request sends zeros
    assert_underflow_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      claim && empty |-> slot_dout == '0);
  end else begin : g_rx
    logic unused_rx;
    assign r_push    = claim;
    assign r_din     = slot_din[SLOT_W-1 -: W];
    assign r_pop     = dat_re;
    assign starve    = full;
    assign irq       = fill_irq(cfg, int'(count));
    assign slot_dout = '0;
    assign dat_rdata = empty ? '0 : head;
    assign unused_rx = ^{dat_we, dat_wdata, slot_din[PAD-1:0], push_ok, pop_ok};

    // R10: an overflowing word never enters the store
    assert_overflow_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      claim && full && !dat_re |=> full);
  end

  // R9 and R10: the error flag rises only after an unmet claim
  assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(claim && starve));
  assert_quiet_disabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.conn != CONN_ON) && !dat_we && !dat_re |=> $stable(count) && !$rose(err));

endmodule

// File: tb/slot_fifo_tb.sv
module slot_fifo_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  logic        t_cfg_we, t_we, t_re, t_stb, t_take, t_irq;
  logic [15:0] t_cfg_wd, t_cfg_rd, t_wd, t_rd;
  logic [3:0]  t_idx;
  logic [19:0] t_din, t_dout;
  logic        r_cfg_we, r_we, r_re, r_stb, r_take, r_irq;
  logic [15:0] r_cfg_wd, r_cfg_rd, r_wd, r_rd;
  logic [3:0]  r_idx;
  logic [19:0] r_din, r_dout;

  slot_fifo #(.IS_TX(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(t_cfg_we), .cfg_wdata(t_cfg_wd), .cfg_rdata(t_cfg_rd),
    .dat_we(t_we), .dat_wdata(t_wd), .dat_re(t_re), .dat_rdata(t_rd),
    .slot_stb(t_stb), .slot_idx(t_idx), .slot_din(t_din), .slot_take(t_take),
    .slot_dout(t_dout), .irq(t_irq));

  slot_fifo #(.IS_TX(1'b0)) u_dut_rx (
    .clk(clk), .rst_n(rst_n), .cfg_we(r_cfg_we), .cfg_wdata(r_cfg_wd), .cfg_rdata(r_cfg_rd),
    .dat_we(r_we), .dat_wdata(r_wd), .dat_re(r_re), .dat_rdata(r_rd),
    .slot_stb(r_stb), .slot_idx(r_idx), .slot_din(r_din), .slot_take(r_take),
    .slot_dout(r_dout), .irq(r_irq));

  logic [15:0] tq[$];
  logic [15:0] rq[$];
  logic [15:0] tcfg = '0;
  logic [15:0] rcfg = '0;
  bit terr = 1'b0;
  bit rerr = 1'b0;

  function automatic bit m_hit(logic [15:0] c, logic [3:0] idx);
    int s;
    s = int'(c[7:4]);
    if (c[1:0] != 2'b10) return 1'b0;
    if (s < 3 || s > 12) return 1'b0;
    if (c[3]) begin
      if (s == 12) return 1'b0;
      return (int'(idx) == s) || (int'(idx) == s + 1);
    end
    return int'(idx) == s;
  endfunction

  function automatic bit m_irq(logic [15:0] c, int n, bit tx);
    int need;
    need = int'(c[10:8]) + 1;
    if (c[1:0] != 2'b10) return 1'b0;
    return tx ? ((8 - n) >= need) : (n >= need);
  endfunction

  function automatic logic [15:0] m_stat(logic [15:0] c, int n, bit e);
    return {e, n == 0, n == 8, 1'b0, c[11:3], 1'b0, c[1:0]};
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle_all();
    t_cfg_we = 0; t_we = 0; t_re = 0; t_stb = 0; t_idx = 0; t_din = 0; t_wd = 0; t_cfg_wd = 0;
    r_cfg_we = 0; r_we = 0; r_re = 0; r_stb = 0; r_idx = 0; r_din = 0; r_wd = 0; r_cfg_wd = 0;
  endtask

  task automatic tx_cycle(string tag, bit we, logic [15:0] wd, bit stb, logic [3:0] idx,
                          bit cw, logic [15:0] cwd);
    bit claim;
    int n;
    t_we = we; t_wd = wd; t_stb = stb; t_idx = idx; t_cfg_we = cw; t_cfg_wd = cwd;
    t_re = 1'($urandom_range(0, 1)); t_din = 20'($urandom);
    #2;
    n = tq.size();
    claim = stb && m_hit(tcfg, idx);
    chk(tag, "tx take", 32'(t_take), 32'(claim));
    chk(tag, "tx dout", 32'(t_dout), (claim && n > 0) ? 32'({tq[0], 4'h0}) : 32'h0);
    chk(tag, "tx irq", 32'(t_irq), 32'(m_irq(tcfg, n, 1'b1)));
    chk(tag, "tx status", 32'(t_cfg_rd), 32'(m_stat(tcfg, n, terr)));
    chk(tag, "tx rdata", 32'(t_rd), 32'h0);
    if (claim && n > 0) void'(tq.pop_front());
    if (we && n < 8) tq.push_back(wd);
    if (claim && n == 0) terr = 1'b1;
    else if (cw && cwd[15]) terr = 1'b0;
    if (cw) tcfg = cwd & 16'h0FFB;
    @(negedge clk);
    t_we = 0; t_stb = 0; t_cfg_we = 0; t_re = 0;
  endtask

  task automatic rx_cycle(string tag, bit re, bit stb, logic [3:0] idx, logic [19:0] din,
                          bit cw, logic [15:0] cwd);
    bit claim;
    int n;
    r_re = re; r_stb = stb; r_idx = idx; r_din = din; r_cfg_we = cw; r_cfg_wd = cwd;
    r_we = 1'($urandom_range(0, 1)); r_wd = 16'($urandom);
    #2;
    n = rq.size();
    claim = stb && m_hit(rcfg, idx);
    chk(tag, "rx take", 32'(r_take), 32'(claim));
    chk(tag, "rx dout", 32'(r_dout), 32'h0);
    chk(tag, "rx irq", 32'(r_irq), 32'(m_irq(rcfg, n, 1'b0)));
    chk(tag, "rx status", 32'(r_cfg_rd), 32'(m_stat(rcfg, n, rerr)));
    chk(tag, "rx rdata", 32'(r_rd), (n > 0) ? 32'(rq[0]) : 32'h0);
    if (re && n > 0) void'(rq.pop_front());
    if (claim && n < 8) rq.push_back(din[19:4]);
    if (claim && n == 8) rerr = 1'b1;
    else if (cw && cwd[15]) rerr = 1'b0;
    if (cw) rcfg = cwd & 16'h0FFB;
    @(negedge clk);
    r_re = 0; r_stb = 0; r_cfg_we = 0; r_we = 0;
  endtask

  function automatic logic [15:0] rand_cfg();
    logic [15:0] w;
    w = 16'($urandom);
    if ($urandom_range(0, 3) != 0) w[1:0] = 2'b10;
    if ($urandom_range(0, 3) != 0) w[7:4] = 4'($urandom_range(3, 12));
    return w;
  endfunction

  function automatic logic [3:0] pick_idx(logic [15:0] c);
    int r;
    r = int'($urandom_range(0, 3));
    if (r == 0) return c[7:4];
    if (r == 1) return c[7:4] + 4'd1;
    return 4'($urandom);
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    idle_all();
    repeat (3) @(negedge clk);
    // R1: reset state of both variants
    chk("R1", "tx status", 32'(t_cfg_rd), 32'h4000);
    chk("R1", "tx irq", 32'(t_irq), 0);
    chk("R1", "tx dout", 32'(t_dout), 0);
    chk("R1", "rx status", 32'(r_cfg_rd), 32'h4000);
    chk("R1", "rx rdata", 32'(r_rd), 0);
    chk("R1", "rx take", 32'(r_take), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // ---------------- transmit variant ----------------
    tx_cycle("R12", 0, 0, 0, 0, 1, 16'h0350);          // slot 5, disconnected
    tx_cycle("R12", 1, 16'h1111, 1, 4'd5, 0, 0);
    tx_cycle("R12", 1, 16'h2222, 1, 4'd5, 1, 16'h0351);
    tx_cycle("R12", 0, 0, 1, 4'd5, 0, 0);
    tx_cycle("R2", 0, 0, 0, 0, 1, 16'hFFFF);           // reserved/read-only bits ignored
    tx_cycle("R2", 0, 0, 0, 0, 1, 16'h0352);           // connect slot 5, threshold 3
    tx_cycle("R2", 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 16; i++) tx_cycle("R3", 0, 0, 1, 4'(i), 0, 0);
    for (int i = 0; i < 10; i++) tx_cycle(i < 8 ? "R5" : "R13", 1, 16'(16'hA000 + i), 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) tx_cycle("R7", 0, 0, 1, 4'd5, 0, 0);
    tx_cycle("R9", 0, 0, 1, 4'd5, 0, 0);                // underflow
    tx_cycle("R9", 0, 0, 0, 0, 0, 0);
    tx_cycle("R11", 0, 0, 0, 0, 1, 16'h8352);           // clear
    tx_cycle("R11", 0, 0, 1, 4'd5, 1, 16'h8352);        // clear and new error together
    tx_cycle("R11", 0, 0, 0, 0, 1, 16'h8352);
    tx_cycle("R8", 0, 0, 0, 0, 1, 16'h0052);
    for (int i = 0; i < 9; i++) tx_cycle("R8", 1, 16'(i), 0, 0, 0, 0);
    tx_cycle("R8", 0, 0, 0, 0, 1, 16'h0752);
    for (int i = 0; i < 8; i++) tx_cycle("R8", 0, 0, 1, 4'd5, 0, 0);
    tx_cycle("R8", 0, 0, 0, 0, 0, 0);
    tx_cycle("R4", 0, 0, 0, 0, 1, 16'h003A);            // stereo slots 3/4
    tx_cycle("R4", 1, 16'h0111, 0, 0, 0, 0);
    tx_cycle("R4", 1, 16'h0222, 0, 0, 0, 0);
    tx_cycle("R4", 1, 16'h0333, 1, 4'd3, 0, 0);
    tx_cycle("R4", 1, 16'h0444, 1, 4'd4, 0, 0);
    tx_cycle("R4", 0, 0, 1, 4'd3, 0, 0);
    tx_cycle("R4", 0, 0, 1, 4'd5, 0, 0);
    tx_cycle("R4", 1, 16'h0555, 0, 0, 1, 16'h00CA);    // stereo at slot 12: nothing
    tx_cycle("R4", 0, 0, 1, 4'd12, 0, 0);
    tx_cycle("R4", 0, 0, 1, 4'd13, 0, 0);
    tx_cycle("R4", 0, 0, 0, 0, 1, 16'h00BA);            // stereo slots 11/12
    tx_cycle("R4", 0, 0, 1, 4'd11, 0, 0);
    tx_cycle("R4", 0, 0, 1, 4'd12, 0, 0);
    tx_cycle("R14", 0, 0, 0, 0, 1, 16'h8052);
    for (int i = 0; i < 8; i++) tx_cycle("R14", 1, 16'(16'hC000 + i), 0, 0, 0, 0);
    tx_cycle("R14", 1, 16'hDEAD, 1, 4'd5, 0, 0);        // full: push dropped, pop taken
    for (int i = 0; i < 7; i++) tx_cycle("R14", 0, 0, 1, 4'd5, 0, 0);
    tx_cycle("R14", 1, 16'hBEEF, 1, 4'd5, 0, 0);        // empty: underflow, push kept
    tx_cycle("R14", 0, 0, 1, 4'd5, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      bit cw;
      logic [15:0] cwd;
      cw  = (i % 200) == 0;
      cwd = rand_cfg();
      tx_cycle("R7", 1'($urandom_range(0, 1)), 16'($urandom), 1'($urandom_range(0, 1)),
               pick_idx(tcfg), cw, cwd);
    end

    // ---------------- receive variant ----------------
    rx_cycle("R6", 0, 0, 0, 0, 1, 16'h0372);            // slot 7, threshold 3
    rx_cycle("R6", 0, 1, 4'd7, 20'hABCDE, 0, 0);
    rx_cycle("R6", 1, 0, 0, 0, 0, 0);
    rx_cycle("R13", 1, 0, 0, 0, 0, 0);                  // pop empty
    rx_cycle("R13", 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 16; i++) rx_cycle("R3", 0, 1, 4'(i), 20'(32'h12340 + i), 0, 0);
    rx_cycle("R5", 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) rx_cycle("R5", 0, 1, 4'd7, 20'(32'h50000 + (i << 4) + i), 0, 0);
    rx_cycle("R10", 0, 1, 4'd7, 20'hFFFFF, 0, 0);      // overflow
    for (int i = 0; i < 8; i++) rx_cycle("R5", 1, 0, 0, 0, 0, 0);
    rx_cycle("R10", 0, 0, 0, 0, 1, 16'h8372);
    for (int i = 0; i < 8; i++) rx_cycle("R14", 0, 1, 4'd7, 20'(32'h60000 + (i << 4)), 0, 0);
    rx_cycle("R14", 1, 1, 4'd7, 20'h77777, 0, 0);      // full: pop taken, word dropped
    rx_cycle("R14", 0, 0, 0, 0, 1, 16'h0370);           // disconnect
    for (int i = 0; i < 4; i++) rx_cycle("R12", 0, 1, 4'd7, 20'h12345, 0, 0);
    for (int i = 0; i < 7; i++) rx_cycle("R12", 1, 0, 0, 0, 0, 0);
    rx_cycle("R8", 0, 0, 0, 0, 1, 16'h8172);
    for (int i = 0; i < 9; i++) rx_cycle("R8", 0, 1, 4'd7, 20'(i << 4), 0, 0);
    for (int i = 0; i < 8; i++) rx_cycle("R8", 1, 0, 0, 0, 0, 0);
    rx_cycle("R4", 0, 0, 0, 0, 1, 16'h009A);            // stereo slots 9/10
    rx_cycle("R4", 0, 1, 4'd9, 20'h11110, 0, 0);
    rx_cycle("R4", 0, 1, 4'd10, 20'h22220, 0, 0);
    rx_cycle("R4", 0, 1, 4'd11, 20'h33330, 0, 0);
    rx_cycle("R4", 1, 0, 0, 0, 0, 0);
    rx_cycle("R4", 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      bit cw;
      logic [15:0] cwd;
      cw  = (i % 200) == 0;
      cwd = rand_cfg();
      rx_cycle("R6", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), pick_idx(rcfg),
               20'($urandom), cw, cwd);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule